// File: doc/BRIEF.md
# Multiplier-Free Piecewise Activation Unit

This block applies one of four neural-network activation functions to a signed fixed-point word and registers the result. A two-bit selector picks rectified linear, leaky rectified linear, a piecewise-linear sigmoid or a piecewise-linear tanh. The selector and the operand are sampled on the same clock edge. The result and its valid flag appear one cycle later.

Every slope in every function is a power of two, so all scaling is done with arithmetic right shifts and constant offsets. No multiplier is inferred. The unit sits inline in a fixed-point datapath with a simple valid strobe and no backpressure. The word is 32-bit two's complement with 16 integer bits and 16 fractional bits, so 1.0 is 0x00010000.

Top module: `pwl_act_unit`

## Requirements
- R1: A sample taken while `inValid` is high appears on `dataOut` exactly one clock edge later, for every function.
- R2: With `fnSel` = 00, the output is the input when the input is greater than zero, and 0 otherwise.
- R3: With `fnSel` = 01, a non-negative input passes through unchanged and a negative input is arithmetically shifted right by 3, so the output is x/8.
- R4: With `fnSel` = 10 (sigmoid), the output is:
  - 0 for x < -3;
  - x/8 + 0.375 (0x6000) for -3 <= x < -1;
  - x/4 + 0.5 (0x8000) for -1 <= x < 1;
  - x/8 + 0.625 (0xA000) for 1 <= x < 3;
  - 1.0 (0x10000) for x >= 3.
- R5: With `fnSel` = 11 (tanh), the output is:
  - -1.0 for x < -2;
  - x/4 - 0.5 for -2 <= x < -1;
  - x/2 - 0.25 for -1 <= x < -0.5;
  - x for -0.5 <= x < 0.5;
  - x/2 + 0.25 for 0.5 <= x < 1;
  - x/4 + 0.5 for 1 <= x < 2;
  - 1.0 for x >= 2.
- R6: Each segment includes its lower breakpoint and excludes its upper breakpoint. For example, x = -1.0 (0xFFFF0000) takes the middle sigmoid segment.
- R7: The function is chosen by the value of `fnSel` at the same edge that captures `dataIn`. Changing the select on every vector switches the function with no extra delay.
- R8: `outValid` equals the value `inValid` had one clock edge earlier.
- R9: While `inValid` is low, `dataOut` holds its previous value, whatever `dataIn` and `fnSel` do.
- R10: A synchronous active-high `rst` clears `outValid` and `dataOut` to zero.
- R11: The sigmoid output always lies in [0, 1.0] and the tanh output always lies in [-1.0, 1.0].
- R12: All divisions by powers of two round toward negative infinity (sign-extending shift). For example, leaky of -1 LSB gives -1 LSB, and leaky of -9 LSB gives -2 LSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operand and select are valid this cycle |
| fnSel | input | 2 | Function select: 00 ReLU, 01 leaky, 10 sigmoid, 11 tanh |
| dataIn | input | 32 | Signed operand, 16 fractional bits |
| outValid | output | 1 | Result register holds a fresh result |
| dataOut | output | 32 | Signed result, 16 fractional bits |

## Verification
Directed vectors sit on every sigmoid and tanh breakpoint and one LSB on either side of it. These separate an inclusive lower bound from an exclusive one, and expose a wrong offset on a neighbouring segment. Small negative codes separate floor rounding from truncation toward zero. Random operands in about ±5.0, with the select changed on every vector, catch wrong slopes and a select sampled on the wrong edge. Full-range random words confirm that the saturated regions hold. Idle cycles that wiggle the data, and a reset in the middle of a run, separate a held output from a freshly loaded or cleared one.

// File: rtl/act_pkg.sv
package act_pkg;

  typedef enum logic [1:0] {
    FN_RELU    = 2'b00,
    FN_LEAKY   = 2'b01,
    FN_SIGMOID = 2'b10,
    FN_TANH    = 2'b11
  } actFn_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic flush;
  } actStrobe_t;

endpackage

// File: rtl/pwl_act_ctrl.sv
module pwl_act_ctrl (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  output act_pkg::actStrobe_t strobe,
  output logic                outValid
);

  always_comb begin
    strobe.flush   = rst;
    strobe.capture = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

endmodule

// File: rtl/pwl_sigmoid.sv
module pwl_sigmoid #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 16
) (
  input  logic signed [DATA_W-1:0] x,
  output logic signed [DATA_W-1:0] y
);

  localparam logic signed [DATA_W-1:0] ONE =
    {{(DATA_W-FRAC_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};
  localparam logic signed [DATA_W-1:0] HALF     = ONE >>> 1;
  localparam logic signed [DATA_W-1:0] QUARTER  = ONE >>> 2;
  localparam logic signed [DATA_W-1:0] EIGHTH   = ONE >>> 3;
  localparam logic signed [DATA_W-1:0] OFS_LOW  = QUARTER + EIGHTH;
  localparam logic signed [DATA_W-1:0] OFS_HIGH = HALF + EIGHTH;
  localparam logic signed [DATA_W-1:0] THREE    = ONE + (ONE <<< 1);
  localparam logic signed [DATA_W-1:0] NEG_ONE  = -ONE;
  localparam logic signed [DATA_W-1:0] NEG_THREE = -THREE;

  always_comb begin
    if (x < NEG_THREE)    y = '0;
    else if (x < NEG_ONE) y = (x >>> 3) + OFS_LOW;
    else if (x < ONE)     y = (x >>> 2) + HALF;
    else if (x < THREE)   y = (x >>> 3) + OFS_HIGH;
    else                  y = ONE;
  end

endmodule

// File: rtl/pwl_tanh.sv
module pwl_tanh #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 16
) (
  input  logic signed [DATA_W-1:0] x,
  output logic signed [DATA_W-1:0] y
);

  localparam logic signed [DATA_W-1:0] ONE =
    {{(DATA_W-FRAC_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};
  localparam logic signed [DATA_W-1:0] TWO      = ONE <<< 1;
  localparam logic signed [DATA_W-1:0] HALF     = ONE >>> 1;
  localparam logic signed [DATA_W-1:0] QUARTER  = ONE >>> 2;
  localparam logic signed [DATA_W-1:0] NEG_ONE  = -ONE;
  localparam logic signed [DATA_W-1:0] NEG_TWO  = -TWO;
  localparam logic signed [DATA_W-1:0] NEG_HALF = -HALF;

  always_comb begin
    if (x < NEG_TWO)       y = NEG_ONE;
    else if (x < NEG_ONE)  y = (x >>> 2) - HALF;
    else if (x < NEG_HALF) y = (x >>> 1) - QUARTER;
    else if (x < HALF)     y = x;
    else if (x < ONE)      y = (x >>> 1) + QUARTER;
    else if (x < TWO)      y = (x >>> 2) + HALF;
    else                   y = ONE;
  end

endmodule

// File: rtl/pwl_act_dp.sv
module pwl_act_dp #(
  parameter int DATA_W      = 32,
  parameter int FRAC_W      = 16,
  parameter int LEAKY_SHIFT = 3
) (
  input  logic                clk,
  input  act_pkg::actStrobe_t strobe,
  input  logic [1:0]          fnSel,
  input  logic [DATA_W-1:0]   dataIn,
  output logic [DATA_W-1:0]   dataOut
);
  import act_pkg::*;

  logic signed [DATA_W-1:0] xS;
  logic signed [DATA_W-1:0] reluVal, leakyVal, sigVal, tanhVal, nextVal;
  logic signed [DATA_W-1:0] resultQ;
  actFn_e                   fn;

  assign xS = $signed(dataIn);
  assign fn = actFn_e'(fnSel);

  assign reluVal  = (xS > 0) ? xS : '0;
  assign leakyVal = xS[DATA_W-1] ? (xS >>> LEAKY_SHIFT) : xS;

  pwl_sigmoid #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) sig_i (.x(xS), .y(sigVal));
  pwl_tanh    #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) tanh_i (.x(xS), .y(tanhVal));

  always_comb begin
    unique case (fn)
      FN_RELU:    nextVal = reluVal;
      FN_LEAKY:   nextVal = leakyVal;
      FN_SIGMOID: nextVal = sigVal;
      FN_TANH:    nextVal = tanhVal;
      default:    nextVal = reluVal;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobe.flush)        resultQ <= '0;
    else if (strobe.capture) resultQ <= nextVal;
  end

  assign dataOut = resultQ;

endmodule

// File: rtl/pwl_act_unit.sv
module pwl_act_unit #(
  parameter int DATA_W      = 32,
  parameter int FRAC_W      = 16,
  parameter int LEAKY_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [1:0]        fnSel,
  input  logic [DATA_W-1:0] dataIn,
  output logic              outValid,
  output logic [DATA_W-1:0] dataOut
);

  act_pkg::actStrobe_t strobe;

  pwl_act_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  pwl_act_dp #(
    .DATA_W      (DATA_W),
    .FRAC_W      (FRAC_W),
    .LEAKY_SHIFT (LEAKY_SHIFT)
  ) dp_i (
    .clk     (clk),
    .strobe  (strobe),
    .fnSel   (fnSel),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

endmodule

// File: rtl/pwl_act_unit_chk.sv
module pwl_act_unit_chk #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [1:0]        fnSel,
  input logic [DATA_W-1:0] dataIn,
  input logic              outValid,
  input logic [DATA_W-1:0] dataOut
);

  localparam logic signed [DATA_W-1:0] ONE =
    {{(DATA_W-FRAC_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};
  localparam logic signed [DATA_W-1:0] NEG_ONE = -ONE;

  logic signed [DATA_W-1:0] outS;
  assign outS = $signed(dataOut);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);                                              // R8
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);                                            // R8
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(dataOut));                                     // R9
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!outValid && dataOut == '0));                       // R10
  AST_SIGMOID_RANGE: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(fnSel) == 2'b10) |-> (outS >= 0 && outS <= ONE)); // R11
  AST_TANH_RANGE: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(fnSel) == 2'b11) |-> (outS >= NEG_ONE && outS <= ONE)); // R11
  AST_RELU_NONNEG: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(fnSel) == 2'b00) |-> !dataOut[DATA_W-1]);        // R2
  AST_LEAKY_SIGN: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(fnSel) == 2'b01) |->
      (dataOut[DATA_W-1] == $past(dataIn[DATA_W-1])));                  // R3

endmodule

bind pwl_act_unit pwl_act_unit_chk #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .fnSel    (fnSel),
  .dataIn   (dataIn),
  .outValid (outValid),
  .dataOut  (dataOut)
);

// File: tb/pwl_act_unit_tb_top.sv
`timescale 1ns/1ps
module pwl_act_unit_tb_top;

  localparam longint ONE = 65536;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [1:0]  fnSel;
  logic [31:0] dataIn;
  logic        outValid;
  logic [31:0] dataOut;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwl_act_unit dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .fnSel(fnSel),
    .dataIn(dataIn), .outValid(outValid), .dataOut(dataOut)
  );

  function automatic longint floorDiv(longint a, longint d);
    if (a >= 0) return a / d;
    return -((-a + d - 1) / d);
  endfunction

  // behavioural model from the requirement text
  function automatic longint model(logic [1:0] fn, longint x);
    case (fn)
      2'b00: return (x > 0) ? x : 0;                          // R2
      2'b01: return (x >= 0) ? x : floorDiv(x, 8);            // R3, R12
      2'b10: begin                                            // R4
        if (x < -3*ONE) return 0;
        if (x < -ONE)   return floorDiv(x, 8) + 24576;
        if (x < ONE)    return floorDiv(x, 4) + 32768;
        if (x < 3*ONE)  return floorDiv(x, 8) + 40960;
        return ONE;
      end
      default: begin                                          // R5
        if (x < -2*ONE)  return -ONE;
        if (x < -ONE)    return floorDiv(x, 4) - 32768;
        if (x < -ONE/2)  return floorDiv(x, 2) - 16384;
        if (x < ONE/2)   return x;
        if (x < ONE)     return floorDiv(x, 2) + 16384;
        if (x < 2*ONE)   return floorDiv(x, 4) + 32768;
        return ONE;
      end
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, sample at the following negedge (one register)
  task automatic apply(input logic [1:0] fn, input longint x, input string req);
    longint exp;
    logic signed [31:0] outS;
    fnSel = fn; dataIn = 32'(x); inValid = 1'b1;
    @(negedge clk);
    exp  = model(fn, longint'($signed(32'(x))));
    outS = $signed(dataOut);
    check(outValid === 1'b1, {req, " R1/R8 valid"}, longint'(outValid), 1);
    check(dataOut === 32'(exp), req, longint'(outS), exp);
    if (fn == 2'b10)
      check(outS >= 0 && outS <= ONE, "R11 sigmoid range", longint'(outS), ONE);
    if (fn == 2'b11)
      check(outS >= -ONE && outS <= ONE, "R11 tanh range", longint'(outS), ONE);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    longint bpsS[4];
    longint bpsT[6];
    logic [31:0] held;
    void'($urandom(32'd20260504));
    bpsS = '{-3*ONE, -ONE, ONE, 3*ONE};
    bpsT = '{-2*ONE, -ONE, -ONE/2, ONE/2, ONE, 2*ONE};
    rst = 1'b1; inValid = 1'b0; fnSel = 2'b00; dataIn = '0;
    repeat (3) @(negedge clk);
    check(outValid === 1'b0, "R10 reset valid", longint'(outValid), 0);
    check(dataOut === 32'd0, "R10 reset data", longint'(dataOut), 0);
    rst = 1'b0;

    // ReLU / leaky corners
    apply(2'b00, 0, "R2 relu zero");
    apply(2'b00, 1, "R2 relu +1lsb");
    apply(2'b00, -1, "R2 relu -1lsb");
    apply(2'b01, 0, "R3 leaky zero");
    apply(2'b01, -8, "R3 leaky -8");
    apply(2'b01, -1, "R12 leaky -1 floors");
    apply(2'b01, -9, "R12 leaky -9 floors");
    apply(2'b01, -32'sd2147483648, "R3 leaky most negative");
    apply(2'b10, -ONE - 1, "R12 sigmoid floor");

    // breakpoints and neighbours
    foreach (bpsS[i])
      for (int d = -1; d <= 1; d++) apply(2'b10, bpsS[i] + d, "R6 sigmoid breakpoint");
    foreach (bpsT[i])
      for (int d = -1; d <= 1; d++) apply(2'b11, bpsT[i] + d, "R6 tanh breakpoint");
    apply(2'b10, -ONE, "R4 sigmoid -1 middle");
    apply(2'b11, 0, "R5 tanh zero");

    // random, select changes every vector
    for (int i = 0; i < 1600; i++) begin
      logic [1:0] fn;
      longint x;
      fn = 2'($urandom_range(0, 3));
      if (i % 4 == 3) x = longint'($signed(32'($urandom())));
      else            x = longint'($urandom_range(0, 10*65536)) - 5*ONE;
      apply(fn, x, "R7 random mix");
    end

    // idle cycles: output holds, valid drops
    apply(2'b11, ONE/4, "R5 tanh quarter");
    held = dataOut;
    for (int i = 0; i < 5; i++) begin
      inValid = 1'b0; fnSel = 2'($urandom_range(0, 3)); dataIn = $urandom();
      @(negedge clk);
      check(outValid === 1'b0, "R8 idle valid", longint'(outValid), 0);
      check(dataOut === held, "R9 hold", longint'(dataOut), longint'(held));
    end

    // reset mid-run
    apply(2'b00, 5*ONE, "R2 relu before reset");
    rst = 1'b1;
    @(negedge clk);
    check(outValid === 1'b0, "R10 mid reset valid", longint'(outValid), 0);
    check(dataOut === 32'd0, "R10 mid reset data", longint'(dataOut), 0);
    rst = 1'b0; inValid = 1'b0;
    apply(2'b10, 3*ONE, "R4 sigmoid after reset");

    done = 1;
    inValid = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule